// File: doc/BRIEF.md
# Mailbox Command Engine

The block holds one 128-bit mailbox register through which software issues commands against a set of queue context slots. Software places a whole command in the mailbox with a single write. When the busy bit of that word is set, the engine accepts the command, keeps busy high for a configurable number of cycles, and then carries it out. A write operation stores the 64-bit base field into the slot picked by the command code and queue number. A read operation puts the slot's stored value back into the base field. Busy then clears and a 4-bit status reports the result. Software learns of completion by polling busy until it reads 0, and then checks that status is zero.

The mailbox word is a plain register, not a stream. A write made while a command is in flight is dropped, so there is no back-pressure. Software must wait for busy to fall before it writes again. A command counter counts every command the engine accepts, for debug.

Top module: `mbx_engine`

## Requirements
- R1: After reset the mailbox reads all zeros and the command counter reads zero.
- R2: A write with bit 13 (busy) set, made while busy is clear, starts a command. Busy reads 1 for exactly EXEC_CYCLES cycles after the write edge and then reads 0.
- R3: Mailbox layout. Bits [8:0] hold the command code. Bits [12:9] hold the status. Bit 13 is busy. Bit 14 is the operation (0 = write, 1 = read). Bits [31:16] hold the queue number. Bits [63:32] hold the base low word and bits [95:64] the base high word. Bits [127:96] hold the token. The status field reads 0 while a command runs.
- R4: A write operation with a context code (0 to 6) and an in-range queue stores the 64-bit base into slot (code, queue). It completes with status 0 and leaves the base field as written.
- R5: A read operation with a context code and an in-range queue completes with status 0 and the slot's stored value in the base field. Code 6 (function table) returns the stored queue allocation. A slot never written reads 0.
- R6: Each (code, queue) pair is its own slot. A write to one slot does not change any other slot.
- R7: Control codes 7, 8, 9, 10, 12, 13 and 14 complete with status 0. They leave the base field as written and change no slot.
- R8: Code 11, and any code above 14, completes with status 1. It changes no slot and leaves the base field as written. This check takes priority over R9.
- R9: A queue number of QUEUES or more completes with status 2. It changes no slot and leaves the base field as written.
- R10: A write made while busy is set is ignored. The running command completes with its own fields, and the counter does not count the dropped write.
- R11: A write with busy clear, made while idle, is stored as written. It starts no command, changes no slot and leaves the counter unchanged.
- R12: The command counter increases by one for each command started, and at no other time.
- R13: Completion keeps the code, operation, queue and token fields exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mb_wr | input | 1 | Single-cycle strobe that writes the whole mailbox |
| mb_wdata | input | 128 | Mailbox word to write |
| mb_rdata | output | 128 | Current mailbox contents |
| cmd_count | output | CNT_W | Number of commands started |

## Verification
The bench tests the exact length of the busy window. An engine that was off by one would finish one poll early or one poll late. It reads back slots never written and slots next to written ones. A wrong slot index would then return another slot's base. It sends a code that is out of range and a queue that is out of range, separately and together. A design that checked them in the wrong order, or skipped the guard, would return the wrong status or overwrite a slot. It writes into a running command and sends a write with busy clear. A design that accepted either one would corrupt the result or advance the counter.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MB_W      = 128;
  localparam int CMD_W     = 9;
  localparam int STAT_LO   = 9;
  localparam int STAT_W    = 4;
  localparam int BUSY_BIT  = 13;
  localparam int OP_BIT    = 14;
  localparam int QUEUE_LO  = 16;
  localparam int QUEUE_W   = 16;
  localparam int BASE_LO   = 32;
  localparam int BASE_W    = 64;
  localparam int TOKEN_LO  = 96;
  localparam int CTX_KINDS = 7;

  typedef enum logic [STAT_W-1:0] {
    ST_OK        = 4'd0,
    ST_BAD_CMD   = 4'd1,
    ST_BAD_QUEUE = 4'd2
  } mbx_status_e;

  typedef enum logic [1:0] {
    CLS_CTX  = 2'd0,
    CLS_CTRL = 2'd1,
    CLS_BAD  = 2'd2
  } cmd_class_e;

  function automatic cmd_class_e classify(input logic [CMD_W-1:0] code);
    if (code < CMD_W'(CTX_KINDS))
      return CLS_CTX;
    else if ((code >= CMD_W'(7) && code <= CMD_W'(10)) ||
             (code >= CMD_W'(12) && code <= CMD_W'(14)))
      return CLS_CTRL;
    else
      return CLS_BAD;
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int QUEUES = 8,
  parameter int SLOT_W = 6
) (
  input  logic [CMD_W-1:0]   code,
  input  logic [QUEUE_W-1:0] queue,
  output mbx_status_e        status,
  output logic               is_ctx,
  output logic [SLOT_W-1:0]  slot
);
  cmd_class_e  cls;
  logic [31:0] flat;

  always_comb begin
    cls    = classify(code);
    is_ctx = (cls == CLS_CTX);
    if (cls == CLS_BAD)
      status = ST_BAD_CMD;
    else if (32'(queue) >= 32'(QUEUES))
      status = ST_BAD_QUEUE;
    else
      status = ST_OK;
    flat = 32'(code) * 32'(QUEUES) + 32'(queue);
    slot = flat[SLOT_W-1:0];
  end
endmodule

// File: rtl/mbx_exec_timer.sv
module mbx_exec_timer #(
  parameter int EXEC_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy,
  output logic done
);
  localparam int TW = (EXEC_CYCLES > 1) ? $clog2(EXEC_CYCLES) : 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start)
      cnt_q <= TW'(EXEC_CYCLES - 1);
    else if (busy && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign done = busy && (cnt_q == '0);
endmodule

// File: rtl/mbx_ctx_store.sv
module mbx_ctx_store #(
  parameter int SLOTS  = 56,
  parameter int DATA_W = 64,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem_q[i] <= '0;
      else if (we && addr == SLOT_W'(i))
        mem_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < SLOTS; i++)
      if (addr == SLOT_W'(i)) rdata = mem_q[i];
  end
endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
  import mbx_pkg::*;
#(
  parameter int QUEUES      = 8,
  parameter int EXEC_CYCLES = 4,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mb_wr,
  input  logic [MB_W-1:0]  mb_wdata,
  output logic [MB_W-1:0]  mb_rdata,
  output logic [CNT_W-1:0] cmd_count
);
  localparam int SLOTS  = CTX_KINDS * QUEUES;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [MB_W-1:0]   mb_q, mb_fin;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy, launch, plain_load, exec_done;
  logic              is_ctx, is_read, ctx_we;
  mbx_status_e       status;
  logic [SLOT_W-1:0] slot;
  logic [BASE_W-1:0] ctx_rdata;

  assign busy       = mb_q[BUSY_BIT];
  assign is_read    = mb_q[OP_BIT];
  assign launch     = mb_wr && !busy && mb_wdata[BUSY_BIT];
  assign plain_load = mb_wr && !busy && !mb_wdata[BUSY_BIT];

  mbx_decode #(.QUEUES(QUEUES), .SLOT_W(SLOT_W)) u_decode (
    .code   (mb_q[CMD_W-1:0]),
    .queue  (mb_q[QUEUE_LO +: QUEUE_W]),
    .status (status),
    .is_ctx (is_ctx),
    .slot   (slot)
  );

  mbx_exec_timer #(.EXEC_CYCLES(EXEC_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (launch),
    .busy  (busy),
    .done  (exec_done)
  );

  assign ctx_we = exec_done && is_ctx && (status == ST_OK) && !is_read;

  mbx_ctx_store #(.SLOTS(SLOTS), .DATA_W(BASE_W), .SLOT_W(SLOT_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctx_we),
    .addr  (slot),
    .wdata (mb_q[BASE_LO +: BASE_W]),
    .rdata (ctx_rdata)
  );

  always_comb begin
    mb_fin                      = mb_q;
    mb_fin[BUSY_BIT]            = 1'b0;
    mb_fin[STAT_LO +: STAT_W]   = status;
    if (is_ctx && status == ST_OK && is_read)
      mb_fin[BASE_LO +: BASE_W] = ctx_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mb_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (launch) begin
        mb_q                    <= mb_wdata;
        mb_q[STAT_LO +: STAT_W] <= '0;
        cnt_q                   <= cnt_q + 1'b1;
      end else if (plain_load) begin
        mb_q <= mb_wdata;
      end else if (exec_done) begin
        mb_q <= mb_fin;
      end
    end
  end

  assign mb_rdata  = mb_q;
  assign cmd_count = cnt_q;
endmodule

// File: rtl/mbx_engine_chk.sv
module mbx_engine_chk
  import mbx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mb_wr,
  input logic [MB_W-1:0]  mb_rdata,
  input logic [CNT_W-1:0] cmd_count,
  input logic             exec_done
);
  logic busy;
  assign busy = mb_rdata[BUSY_BIT];

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !exec_done |=> busy); // R2
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && exec_done |=> !busy); // R2
  AST_LAUNCH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mb_wr)); // R2
  AST_STATUS_ZERO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mb_rdata[STAT_LO +: STAT_W] == '0); // R3
  AST_IGNORE_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !exec_done |=> $stable(mb_rdata)); // R10
  AST_COUNT_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cmd_count == CNT_W'($past(cmd_count) + 1'b1)); // R12
  AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(busy) |-> $stable(cmd_count)); // R11
  AST_FIELDS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && exec_done |=> mb_rdata[127:96] == $past(mb_rdata[127:96]) &&
                          mb_rdata[31:14] == $past(mb_rdata[31:14]) &&
                          mb_rdata[8:0] == $past(mb_rdata[8:0])); // R13
endmodule

bind mbx_engine mbx_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mb_wr     (mb_wr),
  .mb_rdata  (mb_rdata),
  .cmd_count (cmd_count),
  .exec_done (exec_done)
);

// File: tb/mbx_engine_test.sv
module mbx_engine_test;
  localparam int QUEUES = 8;
  localparam int EXEC   = 4;
  localparam int CNT_W  = 16;
  localparam int VW     = 158;
  localparam int NV     = 18;

  localparam logic [63:0] A = 64'h1111_2222_3333_4444;
  localparam logic [63:0] B = 64'h5555_6666_7777_8888;
  localparam logic [63:0] C = 64'h0000_0000_0A00_0010;
  localparam logic [63:0] D = 64'hDEAD_BEEF_0BAD_F00D;
  localparam logic [63:0] E = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] F = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] Z = 64'h0;

  // {op, code, queue, base, expected status, expected base}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 9'd0,   16'd3, A, 4'd0, A},   // R4
    {1'b0, 9'd1,   16'd3, B, 4'd0, B},   // R4
    {1'b0, 9'd6,   16'd0, C, 4'd0, C},   // R4
    {1'b1, 9'd0,   16'd3, Z, 4'd0, A},   // R5
    {1'b1, 9'd1,   16'd3, Z, 4'd0, B},   // R5
    {1'b1, 9'd6,   16'd0, Z, 4'd0, C},   // R5 function table
    {1'b1, 9'd0,   16'd2, Z, 4'd0, Z},   // R6 neighbour slot
    {1'b0, 9'd2,   16'd7, D, 4'd0, D},   // R4
    {1'b1, 9'd2,   16'd7, Z, 4'd0, D},   // R5
    {1'b0, 9'd11,  16'd0, E, 4'd1, E},   // R8
    {1'b1, 9'd15,  16'd0, F, 4'd1, F},   // R8
    {1'b0, 9'd0,   16'd8, E, 4'd2, E},   // R9
    {1'b1, 9'd0,   16'd3, Z, 4'd0, A},   // R6 untouched
    {1'b1, 9'd9,   16'd0, F, 4'd0, F},   // R7
    {1'b0, 9'd14,  16'd1, E, 4'd0, E},   // R7
    {1'b1, 9'd3,   16'd8, F, 4'd2, F},   // R9
    {1'b0, 9'd300, 16'd9, D, 4'd1, D},   // R8 over R9
    {1'b1, 9'd4,   16'd0, Z, 4'd0, Z}    // R5 unwritten
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mb_wr = 1'b0;
  logic [127:0]     mb_wdata = '0;
  logic [127:0]     mb_rdata;
  logic [CNT_W-1:0] cmd_count;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mbx_engine #(.QUEUES(QUEUES), .EXEC_CYCLES(EXEC), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .mb_wr(mb_wr), .mb_wdata(mb_wdata),
    .mb_rdata(mb_rdata), .cmd_count(cmd_count)
  );

  function automatic logic [127:0] mk(input logic op, input logic [8:0] code,
                                      input logic [15:0] q, input logic [63:0] base,
                                      input logic [31:0] tok, input logic bsy);
    logic [127:0] w = '0;
    w[8:0] = code; w[13] = bsy; w[14] = op;
    w[31:16] = q; w[95:32] = base; w[127:96] = tok;
    return w;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [127:0] w, output int cycles);
    @(negedge clk); mb_wr = 1'b1; mb_wdata = w;
    @(negedge clk); mb_wr = 1'b0;
    cycles = 0;
    while (mb_rdata[13] && cycles < 1000) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] w, w2;
    logic [CNT_W-1:0] c0;
    int cyc;
    repeat (3) @(negedge clk);
    check(mb_rdata == '0, "R1 mailbox", mb_rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mb_rdata == '0 && cmd_count == '0, "R1 idle", {mb_rdata[111:0], cmd_count}, '0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v = VEC[i];
      logic [31:0] tok = 32'hC0DE_0000 | 32'(i);
      string tag;
      if (v[67:64] == 4'd1) tag = "R8";
      else if (v[67:64] == 4'd2) tag = "R9";
      else if (i == 6 || i == 12) tag = "R6";
      else if (v[156:148] >= 9'd7) tag = "R7";
      else if (v[157]) tag = "R5";
      else tag = "R4";
      w = mk(v[157], v[156:148], v[147:132], v[131:68], tok, 1'b1);
      run_cmd(w, cyc);
      check(cyc == EXEC, "R2 busy window", 128'(cyc), 128'(EXEC));
      check(mb_rdata[12:9] == v[67:64], tag, 128'(mb_rdata[12:9]), 128'(v[67:64]));
      check(mb_rdata[95:32] == v[63:0], tag, 128'(mb_rdata[95:32]), 128'(v[63:0]));
      check(mb_rdata[127:96] == tok && mb_rdata[31:14] == w[31:14] &&
            mb_rdata[8:0] == w[8:0], "R3/R13 fields", mb_rdata,
            {w[127:96], 64'h0, w[31:14], 5'h0, w[8:0]});
    end
    check(cmd_count == CNT_W'(NV), "R12 count", 128'(cmd_count), 128'(NV));

    // R11: write with busy clear is a plain store
    c0 = cmd_count;
    w = mk(1'b0, 9'd0, 16'd1, E, 32'h1234_5678, 1'b0);
    @(negedge clk); mb_wr = 1'b1; mb_wdata = w;
    @(negedge clk); mb_wr = 1'b0;
    check(mb_rdata == w, "R11 stored", mb_rdata, w);
    repeat (8) @(negedge clk);
    check(mb_rdata == w && cmd_count == c0, "R11 no launch",
          {mb_rdata[111:0], cmd_count}, {w[111:0], c0});
    run_cmd(mk(1'b1, 9'd0, 16'd1, Z, 32'h0, 1'b1), cyc);
    check(mb_rdata[95:32] == Z, "R11 slot unchanged", 128'(mb_rdata[95:32]), 128'(Z));

    // R10: write during busy is dropped
    c0 = cmd_count;
    w  = mk(1'b0, 9'd0, 16'd5, A, 32'hAAAA_0001, 1'b1);
    w2 = mk(1'b0, 9'd0, 16'd5, B, 32'hBBBB_0002, 1'b1);
    @(negedge clk); mb_wr = 1'b1; mb_wdata = w;
    @(negedge clk); mb_wdata = w2;
    @(negedge clk); mb_wr = 1'b0;
    check(mb_rdata == w, "R10 during busy", mb_rdata, w);
    cyc = 0;
    while (mb_rdata[13] && cyc < 1000) begin cyc++; @(negedge clk); end
    check(mb_rdata[95:32] == A && mb_rdata[127:96] == 32'hAAAA_0001,
          "R10 completion", mb_rdata, {32'hAAAA_0001, A, 32'h0});
    check(cmd_count == CNT_W'(c0 + 1'b1), "R10 count",
          128'(cmd_count), 128'(c0 + 1'b1));
    run_cmd(mk(1'b1, 9'd0, 16'd5, Z, 32'h0, 1'b1), cyc);
    check(mb_rdata[95:32] == A, "R10 slot", 128'(mb_rdata[95:32]), 128'(A));

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule